// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable synchronous SRAM. It shares one data timing for reads and writes, so read and write cycles can follow each other on every clock with no idle cycle on the data bus. The block registers address, control and select lines on the rising clock edge. It registers the read data before it reaches the pins. Write data is taken two enabled clocks after its address, which is the same slot in which read data comes out, so the bus direction can change on any cycle.

Each loaded address can be followed by internally generated addresses. A 2-bit counter on the lowest address bits produces them, either in linear order or in interleaved (XOR) order, and the load pin also drives the advance. The array is split into byte lanes with one write enable per lane. An active-low clock enable freezes the whole pipeline. Three chip selects gate each loaded cycle. An asynchronous output enable gates the data drive, and a sleep input blocks new cycles while keeping the stored contents.

Top module: `zbt_sram`

## Requirements
- R1: After reset, dq_drive is 0 and dq_out is 0, and no read or write is pending.
- R2: A read loaded at enabled edge N sets dq_drive to 1 (with oe_n low) and shows the stored word on dq_out after enabled edge N+2. The word holds until the next enabled edge. Nothing is shown after edge N+1.
- R3: A write loaded at enabled edge N takes din and lane_we_n at enabled edge N+2. Lane k covers bits [9k+8:9k], and it is updated only when lane_we_n[k] is 0. The other lanes keep their old value.
- R4: Reads and writes may be loaded on consecutive enabled edges in any mix. Every read returns the latest data, including a read loaded right after a write to the same address.
- R5: With burst_ilv=0, adv_ld_n=1 on an enabled edge continues the loaded cycle. The next address keeps the upper bits and adds 1 (mod 4) to bits [1:0].
- R6: With burst_ilv=1, the burst visits the low two bits in the order s, s^1, s^2, s^3, where s is the loaded value.
- R7: A cycle is selected only if sel_a_n=0, sel_b=1 and sel_c_n=0 at load. A deselected load writes nothing and gives dq_drive=0 in its data slot.
- R8: While clk_en_n=1, edges change nothing: dq_out, dq_drive, the burst position, the pending cycles and the array stay the same, and din is ignored.
- R9: oe_n acts without a clock. While oe_n=1, dq_drive is 0 and dq_out is 0. Setting oe_n back to 0 shows the held read word again.
- R10: While sleep=1, loads and advances start no cycle. The array contents are kept, and a later read returns the data stored before sleep.
- R11: rd_wr=1 at load selects a read and rd_wr=0 a write. During a burst, rd_wr has no effect and the loaded type is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high suspends the pipeline |
| adv_ld_n | input | 1 | Low loads a new address, high advances the burst |
| addr | input | 8 | Word address |
| rd_wr | input | 1 | 1 read, 0 write, sampled at load |
| lane_we_n | input | 4 | Active-low per-lane write enables, sampled in the data slot |
| din | input | 36 | Write data, sampled in the data slot |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | High blocks new cycles |
| burst_ilv | input | 1 | 1 interleaved burst order, 0 linear |
| dq_out | output | 36 | Read data, zero when not driven |
| dq_drive | output | 1 | High while the data bus is driven |

## Verification
A write that commits in its data slot and a read loaded on the next edge to the same address can fall in the same cycle. So can a burst advance and a stall or sleep edge. Random traffic confined to sixteen addresses, with dense write/read mixes, random lane masks and random stalls, makes these collisions frequent. Directed sequences force write-then-read to one address and stalls inside bursts. A bench-side reference model of the array and the two-slot pipeline judges every cycle, comparing dq_drive and dq_out against the word the latest committed lanes imply.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } zbt_op_e;

  // Low address bits for burst step 'stp' from start value 'base'.
  function automatic logic [1:0] burst_idx(input logic [1:0] base,
                                           input logic [1:0] stp,
                                           input logic       ilv);
    return ilv ? (base ^ stp) : (base + stp);
  endfunction

endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen
  import zbt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ld_n,
  input  logic          sel,
  input  logic          sleep,
  input  logic          rd_wr,
  input  logic          ilv,
  input  logic [AW-1:0] addr_i,
  output zbt_op_e       op_o,
  output logic [AW-1:0] addr_o
);

  localparam int HW = AW - 2;

  zbt_op_e       op_q, op_d;
  logic [HW-1:0] hi_q, hi_d;
  logic [1:0]    base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;

  always_comb begin
    op_d   = op_q;
    hi_d   = hi_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (sleep) begin
      op_d = OP_IDLE;
    end else if (!ld_n) begin
      op_d   = sel ? (rd_wr ? OP_RD : OP_WR) : OP_IDLE;
      hi_d   = addr_i[AW-1:2];
      base_d = addr_i[1:0];
      cnt_d  = 2'd0;
    end else if (op_q != OP_IDLE) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      op_q   <= op_d;
      hi_q   <= hi_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign op_o   = op_q;
  assign addr_o = {hi_q, burst_idx(base_q, cnt_q, ilv)};

  AST_BURST_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ld_n && !sleep && op_q != OP_IDLE && !ilv)
      |=> (ilv || addr_o[1:0] == $past(addr_o[1:0]) + 2'd1)); // R5

  AST_BURST_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ld_n && !sleep && op_q != OP_IDLE)
      |=> (op_o == $past(op_o) && addr_o[AW-1:2] == $past(addr_o[AW-1:2]))); // R11

  AST_SLEEP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sleep) |=> (op_o == OP_IDLE)); // R10

  AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> ($stable(op_q) && $stable(cnt_q) && $stable(hi_q))); // R8

endmodule

// File: rtl/zbt_mem.sv
module zbt_mem #(
  parameter int AW = 8,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NL-1:0]    lane_we_n,
  input  logic [NL*LW-1:0] wr_word,
  input  logic [AW-1:0]    rd_addr,
  output logic [NL*LW-1:0] rd_word
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !lane_we_n[g]) begin
        store[wr_addr] <= wr_word[g*LW +: LW];
      end
    end

    assign rd_word[g*LW +: LW] = store[rd_addr];
  end

endmodule

// File: rtl/zbt_rd_pipe.sv
module zbt_rd_pipe
  import zbt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  zbt_op_e       op1_i,
  input  logic [AW-1:0] addr1_i,
  input  logic [DW-1:0] rd_word_i,
  output zbt_op_e       op2_o,
  output logic [AW-1:0] addr2_o,
  output logic [DW-1:0] dout_o,
  output logic          vld_o
);

  zbt_op_e       op2_q, op2_d;
  logic [AW-1:0] addr2_q, addr2_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          vld_q, vld_d;

  always_comb begin
    op2_d   = op1_i;
    addr2_d = addr1_i;
    dout_d  = dout_q;
    vld_d   = 1'b0;
    if (op2_q == OP_RD) begin
      dout_d = rd_word_i;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op2_q   <= OP_IDLE;
      addr2_q <= '0;
      dout_q  <= '0;
      vld_q   <= 1'b0;
    end else if (en) begin
      op2_q   <= op2_d;
      addr2_q <= addr2_d;
      dout_q  <= dout_d;
      vld_q   <= vld_d;
    end
  end

  assign op2_o   = op2_q;
  assign addr2_o = addr2_q;
  assign dout_o  = dout_q;
  assign vld_o   = vld_q;

  AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op2_o == OP_RD) |=> vld_o); // R2

  AST_NO_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op2_o != OP_RD) |=> !vld_o); // R7

  AST_STALL_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> ($stable(dout_o) && $stable(vld_o) && $stable(op2_o))); // R8

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en_n,
  input  logic                      adv_ld_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd_wr,
  input  logic [LANES-1:0]          lane_we_n,
  input  logic [LANES*LANE_W-1:0]   din,
  input  logic                      sel_a_n,
  input  logic                      sel_b,
  input  logic                      sel_c_n,
  input  logic                      oe_n,
  input  logic                      sleep,
  input  logic                      burst_ilv,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_drive
);

  localparam int DW = LANES * LANE_W;

  logic              en;
  logic              sel_all;
  zbt_op_e           op1;
  logic [ADDR_W-1:0] addr1;
  zbt_op_e           op2;
  logic [ADDR_W-1:0] addr2;
  logic [DW-1:0]     rd_word;
  logic [DW-1:0]     dout_q;
  logic              rd_vld;
  logic              commit_wr;

  assign en        = !clk_en_n;
  assign sel_all   = !sel_a_n && sel_b && !sel_c_n;
  assign commit_wr = en && (op2 == OP_WR);

  zbt_burst_gen #(.AW(ADDR_W)) i_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .ld_n   (adv_ld_n),
    .sel    (sel_all),
    .sleep  (sleep),
    .rd_wr  (rd_wr),
    .ilv    (burst_ilv),
    .addr_i (addr),
    .op_o   (op1),
    .addr_o (addr1)
  );

  zbt_rd_pipe #(.AW(ADDR_W), .DW(DW)) i_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .op1_i     (op1),
    .addr1_i   (addr1),
    .rd_word_i (rd_word),
    .op2_o     (op2),
    .addr2_o   (addr2),
    .dout_o    (dout_q),
    .vld_o     (rd_vld)
  );

  zbt_mem #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) i_mem (
    .clk       (clk),
    .wr_en     (commit_wr),
    .wr_addr   (addr2),
    .lane_we_n (lane_we_n),
    .wr_word   (din),
    .rd_addr   (addr2),
    .rd_word   (rd_word)
  );

  assign dq_drive = rd_vld && !oe_n;
  assign dq_out   = dq_drive ? dout_q : '0;

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv_ld_n && !sel_all) |=> (op1 == OP_IDLE)); // R7

  AST_WRITE_TWO_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op1 == OP_WR) |=> (op2 == OP_WR)); // R3

endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, clk_en_n, adv_ld_n, rd_wr, sel_a_n, sel_b, sel_c_n;
  logic oe_n, sleep, burst_ilv;
  logic [AW-1:0] addr;
  logic [NL-1:0] lane_we_n;
  logic [DW-1:0] din, dq_out;
  logic dq_drive;

  zbt_sram i_zbt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld_n(adv_ld_n),
    .addr(addr), .rd_wr(rd_wr), .lane_we_n(lane_we_n), .din(din),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .oe_n(oe_n),
    .sleep(sleep), .burst_ilv(burst_ilv), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit done = 0;

  // reference model: 0 idle, 1 read, 2 write
  logic [DW-1:0] mem_m [1<<AW];
  int m_op, p2_op;
  logic [AW-3:0] m_hi;
  logic [1:0] m_base, m_cnt;
  logic [AW-1:0] p2_addr;
  logic [DW-1:0] e_q;
  logic e_vld;

  function automatic logic [1:0] bidx(logic [1:0] b, logic [1:0] c, logic ilv);
    return ilv ? (b ^ c) : (b + c);
  endfunction

  task automatic model_edge();
    if (p2_op == 2)
      for (int k = 0; k < NL; k++)
        if (!lane_we_n[k]) mem_m[p2_addr][k*LW +: LW] = din[k*LW +: LW];
    if (p2_op == 1) begin e_q = mem_m[p2_addr]; e_vld = 1'b1; end
    else e_vld = 1'b0;
    p2_op   = m_op;
    p2_addr = {m_hi, bidx(m_base, m_cnt, burst_ilv)};
    if (sleep) m_op = 0;
    else if (!adv_ld_n) begin
      m_op   = (!sel_a_n && sel_b && !sel_c_n) ? (rd_wr ? 1 : 2) : 0;
      m_hi   = addr[AW-1:2];
      m_base = addr[1:0];
      m_cnt  = 2'd0;
    end else if (m_op != 0) m_cnt = m_cnt + 2'd1;
  endtask

  task automatic check();
    logic exp_drv;
    logic [DW-1:0] exp_d;
    exp_drv = e_vld && !oe_n;
    exp_d   = exp_drv ? e_q : '0;
    n_chk++;
    if (dq_drive !== exp_drv || dq_out !== exp_d) begin
      n_fail++;
      $display("FAIL %s: got drive=%0b data=%h expected drive=%0b data=%h",
               tag, dq_drive, dq_out, exp_drv, exp_d);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (!clk_en_n) model_edge();
    check();
  endtask

  // sel: {sel_a_n, sel_b, sel_c_n}; 3'b010 selects
  task automatic go(logic ld, logic rw, logic [AW-1:0] a, logic [2:0] sel,
                    logic [DW-1:0] d, logic [NL-1:0] be);
    adv_ld_n = ld; rd_wr = rw; addr = a;
    {sel_a_n, sel_b, sel_c_n} = sel;
    din = d; lane_we_n = be;
    step();
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom(), $urandom()});
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; clk_en_n = 1'b0; adv_ld_n = 1'b0; rd_wr = 1'b1;
    addr = '0; lane_we_n = '1; din = '0; sel_a_n = 1'b1; sel_b = 1'b0;
    sel_c_n = 1'b1; oe_n = 1'b0; sleep = 1'b0; burst_ilv = 1'b0;
    m_op = 0; p2_op = 0; m_hi = '0; m_base = '0; m_cnt = '0;
    p2_addr = '0; e_q = '0; e_vld = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/2);
    rst_n = 1'b1;
    tag = "R1"; check();
    go(1'b0, 1'b1, 8'd0, 3'b000, '0, '1);

    // fill the whole array with full-lane writes back to back
    tag = "R3";
    for (int i = 0; i < (1 << AW); i++) go(1'b0, 1'b0, AW'(i), 3'b010, rnd_word(), '0);
    repeat (2) go(1'b0, 1'b1, 8'd0, 3'b101, rnd_word(), '0);

    // R2: single read latency
    tag = "R2";
    go(1'b0, 1'b1, 8'd5, 3'b010, rnd_word(), '1);
    repeat (3) go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);

    // R3: partial lane write then read back
    tag = "R3";
    go(1'b0, 1'b0, 8'd9, 3'b010, rnd_word(), '1);
    go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);
    go(1'b0, 1'b1, 8'd9, 3'b010, rnd_word(), 4'b1010);
    repeat (3) go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);

    // R4: alternating write/read on one address every cycle
    tag = "R4";
    for (int i = 0; i < 8; i++)
      go(1'b0, i[0], 8'd20, 3'b010, rnd_word(), 4'(i * 5));
    repeat (3) go(1'b0, 1'b1, 8'd20, 3'b010, rnd_word(), '1);

    // R5: linear burst read from 0x26
    tag = "R5"; burst_ilv = 1'b0;
    go(1'b0, 1'b1, 8'h26, 3'b010, rnd_word(), '1);
    repeat (4) go(1'b1, 1'b0, 8'h00, 3'b101, rnd_word(), '1);
    repeat (2) go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);

    // R6: interleaved burst write then interleaved burst read from 0x49
    tag = "R6"; burst_ilv = 1'b1;
    go(1'b0, 1'b0, 8'h49, 3'b010, rnd_word(), '0);
    repeat (3) go(1'b1, 1'b1, 8'h00, 3'b010, rnd_word(), '0);
    go(1'b0, 1'b1, 8'h49, 3'b010, rnd_word(), '0);
    go(1'b1, 1'b1, 8'h00, 3'b010, rnd_word(), '0);
    repeat (4) go(1'b1, 1'b1, 8'h00, 3'b010, rnd_word(), '1);
    go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);
    burst_ilv = 1'b0;

    // R7: each single wrong select blocks a write
    tag = "R7";
    go(1'b0, 1'b0, 8'd30, 3'b110, rnd_word(), '1);
    go(1'b0, 1'b0, 8'd30, 3'b000, rnd_word(), '1);
    go(1'b0, 1'b0, 8'd30, 3'b011, rnd_word(), '0);
    go(1'b0, 1'b1, 8'd30, 3'b110, rnd_word(), '0);
    go(1'b0, 1'b1, 8'd30, 3'b010, rnd_word(), '0);
    repeat (3) go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '0);

    // R8: stall in the middle of a burst and of a write
    tag = "R8";
    go(1'b0, 1'b0, 8'd40, 3'b010, rnd_word(), '1);
    go(1'b0, 1'b1, 8'd41, 3'b010, rnd_word(), '1);
    clk_en_n = 1'b1;
    repeat (3) go(1'b0, 1'b1, 8'd77, 3'b010, rnd_word(), '0);
    clk_en_n = 1'b0;
    go(1'b1, 1'b1, 8'd0, 3'b010, rnd_word(), 4'b0110);
    clk_en_n = 1'b1;
    repeat (2) go(1'b0, 1'b0, 8'd41, 3'b010, rnd_word(), '0);
    clk_en_n = 1'b0;
    go(1'b0, 1'b1, 8'd40, 3'b010, rnd_word(), '1);
    repeat (3) go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);

    // R9: asynchronous output enable while read data is held
    tag = "R9";
    go(1'b0, 1'b1, 8'd7, 3'b010, rnd_word(), '1);
    go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);
    clk_en_n = 1'b1;
    go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);
    clk_en_n = 1'b0;
    go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);
    clk_en_n = 1'b1;
    #(CLK_P/4); oe_n = 1'b1; #1 check();
    oe_n = 1'b0; #1 check();
    clk_en_n = 1'b0;
    go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);

    // R10: sleep blocks loads and bursts, contents kept
    tag = "R10";
    sleep = 1'b1;
    go(1'b0, 1'b0, 8'd50, 3'b010, rnd_word(), '0);
    go(1'b1, 1'b0, 8'd51, 3'b010, rnd_word(), '0);
    go(1'b0, 1'b1, 8'd50, 3'b010, rnd_word(), '0);
    go(1'b1, 1'b1, 8'd50, 3'b010, rnd_word(), '0);
    sleep = 1'b0;
    go(1'b1, 1'b0, 8'd50, 3'b010, rnd_word(), '0);
    go(1'b0, 1'b1, 8'd50, 3'b010, rnd_word(), '0);
    repeat (3) go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '0);

    // R11: rd_wr toggling inside a burst has no effect
    tag = "R11";
    go(1'b0, 1'b1, 8'd60, 3'b010, rnd_word(), '0);
    go(1'b1, 1'b0, 8'd0, 3'b010, rnd_word(), '0);
    go(1'b1, 1'b0, 8'd0, 3'b010, rnd_word(), '0);
    go(1'b0, 1'b0, 8'd61, 3'b010, rnd_word(), '1);
    go(1'b1, 1'b1, 8'd0, 3'b010, rnd_word(), '1);
    go(1'b0, 1'b1, 8'd61, 3'b010, rnd_word(), 4'b0000);
    go(1'b1, 1'b1, 8'd0, 3'b010, rnd_word(), 4'b1100);
    repeat (4) go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);

    // R4: constrained random mix on a small address window
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) burst_ilv = $urandom() % 2;
      clk_en_n = ($urandom() % 10) == 0;
      sleep    = ($urandom() % 25) == 0;
      oe_n     = ($urandom() % 8) == 0;
      go(($urandom() % 4) == 0, $urandom() % 2, AW'($urandom() % 16),
         (($urandom() % 10) != 0) ? 3'b010 : 3'($urandom()),
         rnd_word(), NL'($urandom()));
    end
    clk_en_n = 1'b0; sleep = 1'b0; oe_n = 1'b0;
    tag = "R2";
    for (int i = 0; i < 16; i++) go(1'b0, 1'b1, AW'(i), 3'b010, rnd_word(), '1);
    repeat (3) go(1'b0, 1'b1, 8'd0, 3'b000, rnd_word(), '1);

    done = 1;
    summary();
    $finish;
  end
endmodule